// File: doc/BRIEF.md
# Staggered DRAM Refresh Scheduler

This block decides when DRAM rows get refreshed and which row comes next, so that no row goes longer than the retention window without a refresh. It keeps its own pointer to the next row and raises a refresh request whenever refresh work is owed. The access sequencer answers each request with a grant. Each accepted grant refreshes the row on the address output and moves the pointer on by one.

A two-bit mode input selects the schedule at run time. The spread mode owes one row per fixed interval. The burst mode owes every row at once, once per window, and issues them back to back. The external mode owes a parameterised number of rows on each rising edge of an outside timing pulse. In that mode the pointer carries on from where the previous portion stopped. A fourth mode adds no new work, and any backlog still owed continues to drain. The interval and the window are derived from a clock-rate parameter and the retention time, both rounded down so that the deadline is always met. When grants fall behind, owed refreshes accumulate and are later issued back to back. Owing more than the block can hold raises a sticky error flag.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is active and after it is released, `ref_req`, `ref_done` and `ref_overflow` are 0 and `ref_row` is 0.
- R2: In spread mode (`mode` = 2'b00) one refresh is owed every SPREAD = floor(CLK_KHZ*RETENTION_US/(1000*ROWS)) cycles. The owed count grows on the clock edge where the internal timer has counted SPREAD cycles since reset or since the last mode change, and `ref_req` rises on that edge.
- R3: In burst mode (`mode` = 2'b01), every WINDOW = floor(CLK_KHZ*RETENTION_US/1000) cycles, ROWS refreshes become owed at once. `ref_req` stays high until ROWS grants have been accepted.
- R4: In external mode (`mode` = 2'b10), each rising edge of `ext_tick` (0 in one cycle, 1 in the next) makes ROWS_PER_PULSE refreshes owed. The row pointer continues from its current value.
- R5: In hold mode (`mode` = 2'b11) no new refresh becomes owed. An existing backlog still drains through grants.
- R6: Each accepted grant (`ref_grant` high while `ref_req` is high) advances `ref_row` by one on the next edge, from ROWS-1 back to 0. Otherwise `ref_row` holds its value.
- R7: `ref_req` is high exactly while at least one refresh is owed, so it only falls after a grant. A grant while `ref_req` is low has no effect.
- R8: In spread mode at most QUEUE_MAX refreshes are held. A spread tick that finds QUEUE_MAX still owed after that cycle's grant sets `ref_overflow`, and the backlog stays unchanged.
- R9: A burst or external load that finds refresh work still owed after that cycle's grant sets `ref_overflow` and keeps the remaining backlog instead of reloading it.
- R10: `ref_overflow` stays set until reset.
- R11: `ref_done` is a one-cycle pulse in the cycle after a grant that leaves no refresh owed.
- R12: Any change of `mode` restarts the interval timer from zero. The next spread tick then comes a full SPREAD cycles after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Schedule select: 00 spread, 01 burst, 10 external, 11 hold |
| ext_tick | input | 1 | External timing pulse, acted on at its rising edge in external mode |
| ref_grant | input | 1 | Sequencer accepts the current refresh request |
| ref_req | output | 1 | Refresh work is owed |
| ref_row | output | $clog2(ROWS) | Row to refresh on the next grant |
| ref_done | output | 1 | Backlog emptied by the previous grant |
| ref_overflow | output | 1 | Sticky: owed refreshes exceeded capacity |

## Verification
The bench builds the block with CLK_KHZ=50000, RETENTION_US=8, ROWS=16, QUEUE_MAX=4 and ROWS_PER_PULSE=5. That gives a 25-cycle spread interval and a 400-cycle window. With these values, row wrap-around, two complete bursts, several external portions, a full spread backlog and both kinds of overflow all occur within a few thousand cycles. A behavioural model tracks the owed count, the row pointer and the timer, and the block's outputs are compared against it every cycle while grants are given promptly, withheld, or forced high while nothing is owed.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {
    MODE_SPREAD = 2'b00,
    MODE_BURST  = 2'b01,
    MODE_EXT    = 2'b10,
    MODE_HOLD   = 2'b11
  } sched_mode_t;
endpackage

// File: rtl/drs_pacer.sv
module drs_pacer
  import drs_pkg::*;
#(
  parameter int unsigned SPREAD_CYC = 25,
  parameter int unsigned WINDOW_CYC = 400,
  parameter int unsigned TMR_W      = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  sched_mode_t mode,
  input  logic        ext_tick,
  output logic        tick_spread,
  output logic        tick_window,
  output logic        ext_rise
);
  localparam logic [TMR_W-1:0] SPREAD_LAST = TMR_W'(SPREAD_CYC - 1);
  localparam logic [TMR_W-1:0] WINDOW_LAST = TMR_W'(WINDOW_CYC - 1);

  logic [TMR_W-1:0] timer_q, timer_d;
  sched_mode_t      mode_q;
  logic             ext_q;
  logic             mode_changed;
  logic             at_limit;

  always_comb begin
    mode_changed = (mode != mode_q);
    at_limit     = 1'b0;
    tick_spread  = 1'b0;
    tick_window  = 1'b0;
    timer_d      = '0;
    if (!mode_changed) begin
      unique case (mode)
        MODE_SPREAD: begin
          at_limit    = (timer_q == SPREAD_LAST);
          tick_spread = at_limit;
          timer_d     = at_limit ? '0 : timer_q + 1'b1;
        end
        MODE_BURST: begin
          at_limit    = (timer_q == WINDOW_LAST);
          tick_window = at_limit;
          timer_d     = at_limit ? '0 : timer_q + 1'b1;
        end
        default: timer_d = '0;
      endcase
    end
    ext_rise = ext_tick && !ext_q && (mode == MODE_EXT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      mode_q  <= MODE_SPREAD;
      ext_q   <= 1'b0;
    end else begin
      timer_q <= timer_d;
      mode_q  <= mode;
      ext_q   <= ext_tick;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    timer_q <= WINDOW_LAST) else $error("timer out of range"); // R3
  AST_TICK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_spread && tick_window)) else $error("two ticks at once"); // R2
  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (timer_q == '0)) else $error("timer not restarted"); // R12
endmodule

// File: rtl/drs_backlog.sv
module drs_backlog #(
  parameter int unsigned ROWS           = 16,
  parameter int unsigned QUEUE_MAX      = 4,
  parameter int unsigned ROWS_PER_PULSE = 5,
  parameter int unsigned PEND_W         = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_spread,
  input  logic tick_window,
  input  logic ext_rise,
  input  logic grant,
  output logic owed,
  output logic accept,
  output logic done,
  output logic overflow
);
  localparam logic [PEND_W-1:0] CAP_V   = PEND_W'(QUEUE_MAX);
  localparam logic [PEND_W-1:0] BURST_V = PEND_W'(ROWS);
  localparam logic [PEND_W-1:0] PULSE_V = PEND_W'(ROWS_PER_PULSE);

  logic [PEND_W-1:0] pend_q, pend_d, remain;
  logic              ovf_q, ovf_d;
  logic              done_q, done_d;

  always_comb begin
    owed   = (pend_q != '0);
    accept = owed && grant;
    remain = accept ? pend_q - 1'b1 : pend_q;
    pend_d = remain;
    ovf_d  = ovf_q;
    if (tick_spread) begin
      if (remain >= CAP_V) ovf_d  = 1'b1;
      else                 pend_d = remain + 1'b1;
    end else if (tick_window || ext_rise) begin
      if (remain != '0)     ovf_d  = 1'b1;
      else if (tick_window) pend_d = BURST_V;
      else                  pend_d = PULSE_V;
    end
    done_d = accept && (pend_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign overflow = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q) else $error("overflow cleared"); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !owed) else $error("done while owed"); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (owed && !grant) |=> owed) else $error("request dropped without grant"); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_spread && !accept && pend_q >= CAP_V) |=> ovf_q) else $error("full backlog missed"); // R8
  AST_LOAD_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick_window || ext_rise) && owed && !grant) |=> ovf_q) else $error("load clash missed"); // R9
endmodule

// File: rtl/drs_rowptr.sv
module drs_rowptr #(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (advance) row_d = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (advance) row_q <= row_d;
  end

  assign row = row_q;

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= LAST_ROW) else $error("row out of range"); // R6
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(row_q)) else $error("row moved without grant"); // R6
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drs_pkg::*;
#(
  parameter int unsigned CLK_KHZ        = 200000,
  parameter int unsigned RETENTION_US   = 64000,
  parameter int unsigned ROWS           = 8192,
  parameter int unsigned QUEUE_MAX      = 8,
  parameter int unsigned ROWS_PER_PULSE = 2048,
  localparam int unsigned ROW_W         = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             ext_tick,
  input  logic             ref_grant,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row,
  output logic             ref_done,
  output logic             ref_overflow
);
  localparam longint unsigned WIN_CYC = (64'(CLK_KHZ) * 64'(RETENTION_US)) / 64'd1000;
  localparam longint unsigned SPR_CYC = WIN_CYC / 64'(ROWS);
  localparam int unsigned TMR_W  = $clog2(WIN_CYC + 1);
  localparam int unsigned MAX_A  = (ROWS > QUEUE_MAX) ? ROWS : QUEUE_MAX;
  localparam int unsigned MAX_P  = (MAX_A > ROWS_PER_PULSE) ? MAX_A : ROWS_PER_PULSE;
  localparam int unsigned PEND_W = $clog2(MAX_P + 1);

  sched_mode_t mode_e;
  logic        tick_spread, tick_window, ext_rise, accept;

  assign mode_e = sched_mode_t'(mode);

  drs_pacer #(
    .SPREAD_CYC (int'(SPR_CYC)),
    .WINDOW_CYC (int'(WIN_CYC)),
    .TMR_W      (TMR_W)
  ) u_pacer (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_e),
    .ext_tick    (ext_tick),
    .tick_spread (tick_spread),
    .tick_window (tick_window),
    .ext_rise    (ext_rise)
  );

  drs_backlog #(
    .ROWS           (ROWS),
    .QUEUE_MAX      (QUEUE_MAX),
    .ROWS_PER_PULSE (ROWS_PER_PULSE),
    .PEND_W         (PEND_W)
  ) u_backlog (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_spread (tick_spread),
    .tick_window (tick_window),
    .ext_rise    (ext_rise),
    .grant       (ref_grant),
    .owed        (ref_req),
    .accept      (accept),
    .done        (ref_done),
    .overflow    (ref_overflow)
  );

  drs_rowptr #(
    .ROWS  (ROWS),
    .ROW_W (ROW_W)
  ) u_rowptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .row     (ref_row)
  );

  AST_FALL_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> $past(ref_grant)) else $error("request fell without grant"); // R7
  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_HOLD && $past(mode_e == MODE_HOLD)) |-> !$rose(ref_req))
    else $error("new work in hold mode"); // R5
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int ROWS = 16;
  localparam int QMAX = 4;
  localparam int RPP  = 5;
  localparam int WIN  = 400;
  localparam int SPR  = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       ext_tick = 1'b0;
  logic       ref_grant = 1'b0;
  logic       ref_req, ref_done, ref_overflow;
  logic [3:0] ref_row;

  int checks = 0, failures = 0, cyc = 0;
  bit auto_g = 1'b0, force_g = 1'b0;
  string tag = "R1";
  int req_cnt = 0;

  // behavioural model state
  int m_pend = 0, m_row = 0, m_timer = 0;
  bit m_ovf = 0, m_done = 0, m_ext_q = 0;
  logic [1:0] m_mode_q = 2'b00;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .CLK_KHZ(50000), .RETENTION_US(8), .ROWS(ROWS),
    .QUEUE_MAX(QMAX), .ROWS_PER_PULSE(RPP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ext_tick(ext_tick),
    .ref_grant(ref_grant), .ref_req(ref_req), .ref_row(ref_row),
    .ref_done(ref_done), .ref_overflow(ref_overflow)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_row = 0; m_timer = 0; m_ovf = 0; m_done = 0;
      m_ext_q = 0; m_mode_q = 2'b00;
    end else begin
      bit acc, tick, rise;
      int lim, rem;
      acc  = (m_pend > 0) && ref_grant;
      tick = 0;
      lim  = (mode == 2'b00) ? SPR : (mode == 2'b01) ? WIN : 0;
      if (mode != m_mode_q || lim == 0) m_timer = 0;
      else if (m_timer == lim - 1) begin tick = 1; m_timer = 0; end
      else m_timer++;
      m_mode_q = mode;
      rise = ext_tick && !m_ext_q && mode == 2'b10;
      m_ext_q = ext_tick;
      rem = acc ? m_pend - 1 : m_pend;
      m_pend = rem;
      if (tick && mode == 2'b00) begin
        if (rem >= QMAX) m_ovf = 1; else m_pend = rem + 1;
      end else if ((tick && mode == 2'b01) || rise) begin
        if (rem != 0) m_ovf = 1; else m_pend = (mode == 2'b01) ? ROWS : RPP;
      end
      m_done = acc && m_pend == 0;
      if (acc) m_row = (m_row + 1) % ROWS;
    end
  end

  task automatic check(input string t, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, ref_req,      m_pend > 0, "req");
      check(tag, ref_row,      m_row,      "row");
      check(tag, ref_done,     m_done,     "done");
      check(tag, ref_overflow, m_ovf,      "overflow");
      if (ref_req) req_cnt++;
    end
    ref_grant = auto_g ? ref_req : force_g;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    run(3);
    check("R1", ref_req, 0, "req in reset");
    check("R1", ref_row, 0, "row in reset");
    check("R1", ref_done | ref_overflow, 0, "flags in reset");
    rst_n = 1'b1;
  endtask

  task automatic pulse();
    ext_tick = 1'b1; run(1); ext_tick = 1'b0;
  endtask

  initial begin
    do_reset();
    // R2 spread with prompt grants
    tag = "R2"; mode = 2'b00; auto_g = 1; run(SPR * 8 + 5);
    // R12 mode change restarts timer
    tag = "R12"; run(10); mode = 2'b01; run(3); mode = 2'b00; run(SPR * 3);
    // R8 backlog fills without grants, then overflows
    tag = "R8"; auto_g = 0; force_g = 0; run(SPR * 6);
    check("R8", ref_overflow, 1, "overflow after full backlog");
    check("R8", ref_req, 1, "req held with backlog");
    // R10 sticky while draining; R11 done after drain
    tag = "R10"; auto_g = 1; run(20);
    check("R10", ref_overflow, 1, "overflow stays");
    do_reset();
    // R3 burst, two windows, R6 wrap
    tag = "R3"; mode = 2'b01; auto_g = 1; req_cnt = 0; run(WIN * 2 + 50);
    check("R3", req_cnt, 2 * ROWS, "request cycles over two windows");
    check("R6", ref_row, 0, "row after wrap");
    // R4 external portions continue the pointer
    tag = "R4"; mode = 2'b10; run(2);
    for (int i = 0; i < 3; i++) begin pulse(); run(15); end
    check("R4", ref_row, 3 * RPP % ROWS, "row after three portions");
    // R9 second pulse while work owed
    tag = "R9"; auto_g = 0; force_g = 0; pulse(); run(3); pulse(); run(3);
    check("R9", ref_overflow, 1, "overflow on load clash");
    tag = "R11"; auto_g = 1; run(15);
    do_reset();
    // R5 hold mode and R7 idle grants
    tag = "R5"; mode = 2'b11; auto_g = 0; force_g = 1; run(WIN + 20);
    check("R5", ref_req, 0, "no work in hold");
    check("R7", ref_row, 0, "idle grants ignored");
    force_g = 0;
    tag = "R6"; mode = 2'b00; auto_g = 1; run(SPR * ROWS + 10);
    check("R6", ref_row, ROWS % ROWS, "row wraps after ROWS spread refreshes");
    finish_run();
  end
endmodule